// File: doc/BRIEF.md
# System Interrupt Router with Per-CPU Soft Levels

This block gathers 32 external interrupt lines into one shared set of system registers and delivers them to a single selected CPU. For each CPU it also keeps a soft-interrupt register that software can set and clear. For every CPU it builds a 16-bit level vector and outputs a 4-bit number: the highest level that is active.

Software uses a word-addressed port. One bit selects either the system window or the window of one CPU. The two windows differ in how they treat the data, as follows:

- **System window.** Enable and disable use two separate write words. Written data is filtered through a fixed mask of usable bits, and bits outside that mask are ignored.
- **Per-CPU window.** Set and clear also use separate words. Only the high fifteen bits are honoured. These bits feed levels 15 down to 1 of that CPU directly.

The mapping from each source to its level is a build-time parameter.

Top module: `intc_top`

## Requirements
- R1: After reset, the system pending register, every soft register and the target CPU are zero. The disable register holds 0x4fb2007f, and every level output is 0.
- R2: With regIsCpu low, the read data for each word is:
  - word 0: the system pending register with bit 31 forced to 0
  - word 1: the disable register
  - word 4: the target CPU, zero-extended
  - any other word: 0
- R3: A system write to word 2 clears the bits of (data AND 0xb04dff80) in the disable register.
- R4: A system write to word 3 sets the bits of (data AND 0xb04dff80) in the disable register and clears the same bits in the pending register. This clear wins over an input edge that arrives in the same cycle.
- R5: While bit 31 of the disable register is set, no system source contributes to any CPU's level.
- R6: A source j that is pending and whose disable bit is clear sets level LEVEL_MAP[4j+3:4j]. It does so only in the CPU whose index equals the target register.
- R7: A per-CPU write to word 2 ORs (data AND 0xfffe0000) into that CPU's soft register. Soft bits 31..17 drive levels 15..1, and word 0 of the per-CPU window reads the soft register. A CPU index at or above NUM_CPU reads 0 and writes nothing.
- R8: A per-CPU write to word 1 clears the bits of (data AND 0xfffe0000) in the soft register. If bit 14 of the data is set, bit 31 is cleared as well.
- R9: A system write to word 4 loads the target register when the data is below NUM_CPU. Otherwise the write is ignored.
- R10: A 0-to-1 change on irqIn[j] sets pending bit j one clock later, but only if bit j is set in 0xb04dff80. A line held high does not set its bit again.
- R11: Each CPU's 4-bit output is the index of the highest set bit of its level vector, or 0 if none is set. Level bit 0 never produces a non-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | External interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regIsCpu | input | 1 | 0 selects the system window, 1 selects a per-CPU window |
| regCpuSel | input | CPU_W | CPU index for the per-CPU window |
| regWord | input | 3 | Word index inside the window |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data (combinational) |
| cpuLevel | output | NUM_CPU*4 | Highest active level, 4 bits per CPU |

## Verification
The bench builds the block with NUM_CPU = 3, which leaves a 2-bit CPU index with one value that names no CPU. This makes the ignored target writes and the dead per-CPU index reachable. The bench's own level table is 15 minus (j mod 16). As a result, sources 15 and 31 land on level 0, which can never appear at an output, and most other levels are shared by two sources.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_N  = 32;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 4;
  localparam int LVL_N  = 16;
  localparam int WORD_W = 3;

  localparam logic [DATA_W-1:0] USABLE_MASK = 32'hb04dff80;
  localparam logic [DATA_W-1:0] SOFT_MASK   = 32'hfffe0000;
  localparam int MASTER_OFF_BIT = 31;
  localparam int SOFT_ALIAS_BIT = 14;

  // system window words
  localparam logic [WORD_W-1:0] SW_PEND   = 3'd0;
  localparam logic [WORD_W-1:0] SW_DIS    = 3'd1;
  localparam logic [WORD_W-1:0] SW_ENABLE = 3'd2;
  localparam logic [WORD_W-1:0] SW_MUTE   = 3'd3;
  localparam logic [WORD_W-1:0] SW_TARGET = 3'd4;
  // per-cpu window words
  localparam logic [WORD_W-1:0] CW_PEND   = 3'd0;
  localparam logic [WORD_W-1:0] CW_CLEAR  = 3'd1;
  localparam logic [WORD_W-1:0] CW_SET    = 3'd2;

  typedef struct packed {
    logic sysEnable;
    logic sysMute;
    logic softClear;
    logic softSet;
    logic tgtWrite;
  } strobe_t;

  function automatic logic [SRC_N*LVL_W-1:0] defaultLevelMap();
    logic [SRC_N*LVL_W-1:0] m;
    m = '0;
    for (int j = 0; j < SRC_N; j++) m[j*LVL_W +: LVL_W] = LVL_W'((j % 15) + 1);
    return m;
  endfunction
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              regWrEn,
  input  logic              regIsCpu,
  input  logic [CPU_W-1:0]  regCpuSel,
  input  logic [WORD_W-1:0] regWord,
  input  logic [DATA_W-1:0] regWData,
  output strobe_t           stb,
  output logic              cpuValid
);
  logic tgtInRange;

  always_comb begin
    cpuValid   = 32'(regCpuSel) < 32'(NUM_CPU);
    tgtInRange = regWData < 32'(NUM_CPU);
    stb = '0;
    if (regWrEn) begin
      if (!regIsCpu) begin
        stb.sysEnable = (regWord == SW_ENABLE);
        stb.sysMute   = (regWord == SW_MUTE);
        stb.tgtWrite  = (regWord == SW_TARGET) && tgtInRange;
      end else if (cpuValid) begin
        stb.softClear = (regWord == CW_CLEAR);
        stb.softSet   = (regWord == CW_SET);
      end
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = intc_pkg::defaultLevelMap(),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_N-1:0]         irqIn,
  input  strobe_t                  stb,
  input  logic                     cpuValid,
  input  logic                     regIsCpu,
  input  logic [CPU_W-1:0]         regCpuSel,
  input  logic [WORD_W-1:0]        regWord,
  input  logic [DATA_W-1:0]        regWData,
  output logic [DATA_W-1:0]        regRData,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);
  logic [SRC_N-1:0]  sysPend, sysDis, irqPrev, riseBits, maskedBits, effBits;
  logic [CPU_W-1:0]  tgtCpu;
  logic [DATA_W-1:0] softPend [NUM_CPU];
  logic [DATA_W-1:0] softClrBits;
  logic [LVL_N-1:0]  routedVec;

  assign riseBits   = irqIn & ~irqPrev & USABLE_MASK;
  assign maskedBits = regWData & USABLE_MASK;
  assign effBits    = sysPend & ~sysDis;

  always_comb begin
    softClrBits = regWData;
    if (regWData[SOFT_ALIAS_BIT]) softClrBits[MASTER_OFF_BIT] = 1'b1;
    softClrBits = softClrBits & SOFT_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysPend <= '0;
      sysDis  <= ~USABLE_MASK;
      irqPrev <= '0;
      tgtCpu  <= '0;
    end else begin
      irqPrev <= irqIn;
      if (stb.sysMute) sysPend <= (sysPend | riseBits) & ~maskedBits;
      else             sysPend <= sysPend | riseBits;
      if (stb.sysEnable)   sysDis <= sysDis & ~maskedBits;
      else if (stb.sysMute) sysDis <= sysDis | maskedBits;
      if (stb.tgtWrite) tgtCpu <= regWData[CPU_W-1:0];
    end
  end

  // system sources folded onto levels, gated by the master-off bit
  always_comb begin
    routedVec = '0;
    for (int j = 0; j < SRC_N; j++)
      if (effBits[j]) routedVec[LEVEL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
    if (sysDis[MASTER_OFF_BIT]) routedVec = '0;
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    logic [LVL_N-1:0] lvlVec;
    logic [LVL_W-1:0] lvlOut;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) softPend[i] <= '0;
      else if (32'(regCpuSel) == i) begin
        if (stb.softSet)        softPend[i] <= softPend[i] | (regWData & SOFT_MASK);
        else if (stb.softClear) softPend[i] <= softPend[i] & ~softClrBits;
      end
    end

    always_comb begin
      lvlVec = ((tgtCpu == CPU_W'(i)) ? routedVec : '0) | softPend[i][DATA_W-1 -: LVL_N];
      lvlOut = '0;
      for (int k = 0; k < LVL_N; k++) if (lvlVec[k]) lvlOut = LVL_W'(k);
    end
    assign cpuLevel[i*LVL_W +: LVL_W] = lvlOut;

    p_soft_low_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
      softPend[i][16:0] == '0);
    p_master_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      (sysDis[MASTER_OFF_BIT] && softPend[i] == '0) |-> lvlOut == '0);
  end

  always_comb begin
    regRData = '0;
    if (!regIsCpu) begin
      case (regWord)
        SW_PEND:   regRData = sysPend & ~(32'h1 << MASTER_OFF_BIT);
        SW_DIS:    regRData = sysDis;
        SW_TARGET: regRData = 32'(tgtCpu);
        default:   regRData = '0;
      endcase
    end else if (cpuValid && regWord == CW_PEND) begin
      for (int c = 0; c < NUM_CPU; c++)
        if (32'(regCpuSel) == c) regRData = softPend[c];
    end
  end

  p_read_top_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!regIsCpu && regWord == SW_PEND) |-> !regRData[MASTER_OFF_BIT]);
  p_mute_clears_pend_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.sysMute) |-> (sysPend & $past(maskedBits)) == '0);
  p_tgt_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    32'(tgtCpu) < 32'(NUM_CPU));
  p_unusable_never_pend_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sysPend & ~USABLE_MASK) == '0);
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = intc_pkg::defaultLevelMap(),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_N-1:0]         irqIn,
  input  logic                     regWrEn,
  input  logic                     regIsCpu,
  input  logic [CPU_W-1:0]         regCpuSel,
  input  logic [WORD_W-1:0]        regWord,
  input  logic [DATA_W-1:0]        regWData,
  output logic [DATA_W-1:0]        regRData,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);
  strobe_t stb;
  logic    cpuValid;

  intc_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
    .regWrEn(regWrEn), .regIsCpu(regIsCpu), .regCpuSel(regCpuSel),
    .regWord(regWord), .regWData(regWData), .stb(stb), .cpuValid(cpuValid)
  );

  intc_datapath #(.NUM_CPU(NUM_CPU), .LEVEL_MAP(LEVEL_MAP)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .cpuValid(cpuValid),
    .regIsCpu(regIsCpu), .regCpuSel(regCpuSel), .regWord(regWord),
    .regWData(regWData), .regRData(regRData), .cpuLevel(cpuLevel)
  );
endmodule

// File: tb/intc_top_bench.sv
module intc_top_bench;
  localparam int NCPU = 3;
  localparam int CW = 2;

  function automatic logic [127:0] benchMap();
    logic [127:0] m;
    for (int j = 0; j < 32; j++) m[j*4 +: 4] = 4'(15 - (j % 16));
    return m;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic regWrEn = 1'b0, regIsCpu = 1'b0;
  logic [CW-1:0] regCpuSel = '0;
  logic [2:0] regWord = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic [NCPU*4-1:0] cpuLevel;

  intc_top #(.NUM_CPU(NCPU), .LEVEL_MAP(benchMap())) u_intc_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn), .regIsCpu(regIsCpu),
    .regCpuSel(regCpuSel), .regWord(regWord), .regWData(regWData),
    .regRData(regRData), .cpuLevel(cpuLevel)
  );

  always #4 clk = ~clk;

  // reference model
  logic [31:0] mPend = 0, mDis = 32'h4fb2007f, mPrev = 0;
  int mTgt = 0;
  logic [31:0] mSoft [NCPU] = '{default: 0};
  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1";
  bit finished = 0;

  function automatic int expLevel(int i);
    int vec = 0;
    if (i == mTgt && !mDis[31])
      for (int j = 0; j < 32; j++)
        if (mPend[j] && !mDis[j]) vec |= 1 << (15 - (j % 16));
    vec |= int'(mSoft[i] >> 16) & 32'hfffe;
    for (int k = 15; k >= 1; k--) if (vec[k]) return k;
    return 0;
  endfunction

  function automatic logic [31:0] expRead();
    if (!regIsCpu) begin
      case (regWord)
        3'd0: return mPend & 32'h7fffffff;
        3'd1: return mDis;
        3'd4: return 32'(mTgt);
        default: return 0;
      endcase
    end
    if (int'(regCpuSel) < NCPU && regWord == 3'd0) return mSoft[regCpuSel];
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] rise, v;
    if (!rstN) begin
      mPend = 0; mDis = 32'h4fb2007f; mPrev = 0; mTgt = 0;
      for (int i = 0; i < NCPU; i++) mSoft[i] = 0;
    end else begin
      rise = irqIn & ~mPrev & 32'hb04dff80;
      mPend = mPend | rise;
      mPrev = irqIn;
      v = regWData & 32'hb04dff80;
      if (regWrEn && !regIsCpu) begin
        if (regWord == 3'd2) mDis = mDis & ~v;
        if (regWord == 3'd3) begin mDis = mDis | v; mPend = mPend & ~v; end
        if (regWord == 3'd4 && regWData < NCPU) mTgt = int'(regWData);
      end
      if (regWrEn && regIsCpu && int'(regCpuSel) < NCPU) begin
        if (regWord == 3'd2) mSoft[regCpuSel] = mSoft[regCpuSel] | (regWData & 32'hfffe0000);
        if (regWord == 3'd1) begin
          v = regWData;
          if (v[14]) v[31] = 1'b1;
          mSoft[regCpuSel] = mSoft[regCpuSel] & ~(v & 32'hfffe0000);
        end
      end
    end
    #3;
    compared++;
    if (regRData !== expRead()) begin
      mismatched++;
      $display("FAIL %s: read actual %h expected %h", phase, regRData, expRead());
    end
    for (int i = 0; i < NCPU; i++) begin
      compared++;
      if (int'(cpuLevel[i*4 +: 4]) != expLevel(i) || $isunknown(cpuLevel[i*4 +: 4])) begin
        mismatched++;
        $display("FAIL %s (R11): cpu%0d level actual %0d expected %0d", phase, i,
                 cpuLevel[i*4 +: 4], expLevel(i));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(bit isCpu, int cpu, int word);
    @(negedge clk);
    regWrEn = 0; regIsCpu = isCpu; regCpuSel = CW'(cpu); regWord = 3'(word);
  endtask

  task automatic wr(bit isCpu, int cpu, int word, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regIsCpu = isCpu; regCpuSel = CW'(cpu); regWord = 3'(word); regWData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  initial begin
    logic [31:0] lfsr = 32'h1ace_b00c;
    phase = "R1"; idle(3);
    rstN = 1'b1;
    look(0, 0, 1); idle(1);
    phase = "R2";
    for (int w = 0; w < 8; w++) look(0, 0, w);
    phase = "R10";
    look(0, 0, 0);
    @(negedge clk); irqIn = 32'h8000_0081;   // bit 7 usable, bit 0 not, bit 31 usable
    idle(3); irqIn = 0; idle(2);
    irqIn = 32'h0000_0100; idle(2);
    phase = "R4";
    wr(0, 0, 3, 32'h0000_0100);               // clears pend bit 8; held line must not re-set
    idle(2); irqIn = 0;
    @(negedge clk); irqIn = 32'h0000_0200; regWrEn = 1; regIsCpu = 0; regWord = 3; regWData = 32'h200;
    @(negedge clk); regWrEn = 0; irqIn = 0;
    look(0, 0, 1); idle(2);
    phase = "R3";
    wr(0, 0, 2, 32'hffff_ffff); look(0, 0, 1); idle(1);
    phase = "R6";
    @(negedge clk); irqIn = 32'h0000_8400; idle(2); irqIn = 0;
    look(0, 0, 0); idle(2);
    phase = "R9";
    wr(0, 0, 4, 2); look(0, 0, 4); idle(1);
    wr(0, 0, 4, 3); idle(1);
    wr(0, 0, 4, 32'h1_0001); idle(1);
    wr(0, 0, 4, 1); idle(1);
    phase = "R5";
    wr(0, 0, 3, 32'h8000_0000); idle(2);
    @(negedge clk); irqIn = 32'h0001_0000; idle(2); irqIn = 0;
    wr(0, 0, 2, 32'h8000_0000); idle(2);
    phase = "R7";
    wr(1, 1, 2, 32'hffff_ffff); look(1, 1, 0); idle(1);
    wr(1, 2, 2, 32'h0002_0000); look(1, 2, 0); idle(1);
    wr(1, 3, 2, 32'hffff_ffff); look(1, 3, 0); idle(1);
    phase = "R8";
    wr(1, 1, 1, 32'h0000_4000); look(1, 1, 0); idle(1);
    wr(1, 1, 1, 32'h7ffc_0000); look(1, 1, 0); idle(1);
    wr(1, 2, 1, 32'h0001_ffff); idle(1);
    phase = "MIX";
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      irqIn = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      regWrEn = lfsr[3]; regIsCpu = lfsr[4]; regCpuSel = CW'(lfsr[6:5]);
      regWord = lfsr[9:7] % 5; regWData = {lfsr[12:0], lfsr[31:13]};
      if (regWord == 4) regWData = 32'(lfsr[11:10]);
    end
    @(negedge clk); regWrEn = 0;
    idle(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule